// File: doc/BRIEF.md
# Configurable NAND/NOR Logic Cone

This block is a combinational logic element shaped as a balanced binary tree of two-input gates. Each gate is set by one static configuration bit to behave as either a NAND or a NOR. With the default depth of six levels, the block takes 64 leaf signals. It feeds them through 32, 16, 8, 4, 2 and finally 1 gate. It brings out every gate of level 3 and above, which gives 15 tap outputs.

Configuration is a wide static vector that stands in for memory cells holding the element's programming. It carries one function bit per gate and one polarity bit per leaf. A build parameter selects where the optional leaf inversion happens:

- With the parameter at 0, the cone applies the polarity bits to the leaves itself.
- With the parameter at 1, the leaves are taken to arrive already in the wanted polarity from an upstream input stage, and the polarity bits are left unused.

Because NAND and NOR are related by De Morgan's laws, a mapper's AND/inverter network of the same depth can be placed onto this tree. For that reason the tree is defined purely by its Boolean behaviour.

Top module: `nn_cone`

## Requirements
- R1: A gate whose function bit is 0 computes NAND of its two inputs; a gate whose function bit is 1 computes NOR.
- R2: Gate j of level L (L ≥ 2) takes gate 2j of level L−1 as its first input and gate 2j+1 as its second; gate j of level 1 takes polarised leaves 2j and 2j+1.
- R3: With EXT_INV = 0, polarity bit i (cfg bit NODES + i) set to 1 inverts leaf i before it enters level 1; at 0 the leaf passes unchanged.
- R4: With EXT_INV = 1, every polarity bit has no effect on any tap output.
- R5: Function bits are packed level by level from the bottom, starting with gate 0 of level 1 at cfg bit 0: level L starts at bit LEAVES − (LEAVES >> (L−1)). Polarity bits follow from bit NODES (63 at default), with leaf 0 lowest.
- R6: Tap outputs list the gates of levels TAP_FIRST..LEVELS in rising level order, gate 0 of each level first. At default, taps 0–7 are level 3, taps 8–11 are level 4, taps 12–13 are level 5 and tap 14 is the root.
- R7: An all-NAND cone with all leaves at 1 shows alternating constants per level: level 3 is 0, level 4 is 1, level 5 is 0 and level 6 is 1 (tap word 0x4F00). An all-NAND or all-NOR cone with all leaves at 0 gives tap word 0x30FF.
- R8: The block is purely combinational: a change on the leaves or on the configuration is seen at the taps with no clock and no stored state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| leaf_in | input | LEAVES (64) | Leaf signals entering level 1 |
| cfg | input | NODES+LEAVES (127) | Static configuration: gate function bits, then leaf polarity bits |
| tap_out | output | 15 | Outputs of the gates in levels 3 to 6 |

## Verification
The assertions sit inside each gate and each leaf polarity stage. They check absorbing values: a 1 into a NOR forces 0, a 0 into a NAND forces 1, and a set polarity bit always produces a differing level. They assume settled two-valued inputs, so they are evaluated in the same block that forms the result, where no half-updated value can be seen. The stimulus drives the leaves and the configuration only with 0 and 1 and changes them away from the sampling point. It mixes directed constant patterns with random vectors, in which every gate function and polarity bit is drawn freely.

// File: rtl/nn_cone_pkg.sv
package nn_cone_pkg;

  // First configuration bit (and first flat node index) of a tree level.
  function automatic int unsigned lvl_base(input int unsigned leaves, input int unsigned lvl);
    return leaves - (leaves >> (lvl - 1));
  endfunction

  // Number of gates in a tree level.
  function automatic int unsigned lvl_count(input int unsigned leaves, input int unsigned lvl);
    return leaves >> lvl;
  endfunction

  // Two-input gate: sel_nor = 0 gives NAND, 1 gives NOR.
  function automatic logic nn_gate(input logic a, input logic b, input logic sel_nor);
    return sel_nor ? ~(a | b) : ~(a & b);
  endfunction

endpackage

// File: rtl/nn_node.sv
module nn_node
  import nn_cone_pkg::*;
(
  input  logic in_a,
  input  logic in_b,
  input  logic sel_nor,
  output logic y
);

  always_comb begin
    y = nn_gate(in_a, in_b, sel_nor);
    if (sel_nor && (in_a || in_b))   AST_NOR_ABSORB:  assert (y == 1'b0); // R1
    if (!sel_nor && !(in_a && in_b)) AST_NAND_ABSORB: assert (y == 1'b1); // R1
    if (sel_nor && !in_a && !in_b)   AST_NOR_ALL_LO:  assert (y == 1'b1); // R1
    if (!sel_nor && in_a && in_b)    AST_NAND_ALL_HI: assert (y == 1'b0); // R1
  end

endmodule

// File: rtl/nn_leaf_pol.sv
module nn_leaf_pol #(
  parameter int unsigned WIDTH   = 64,
  parameter bit          EXT_INV = 1'b0
) (
  input  logic [WIDTH-1:0] raw,
  input  logic [WIDTH-1:0] flip,
  output logic [WIDTH-1:0] pol
);

  generate
    if (EXT_INV) begin : g_ext
      // Upstream stage already delivers the wanted polarity.
      assign pol = raw;
      logic unused_flip;
      assign unused_flip = ^flip;
    end else begin : g_int
      for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        always_comb begin
          pol[i] = flip[i] ? ~raw[i] : raw[i];
          AST_POL_FLIP: assert (flip[i] ? (pol[i] != raw[i]) : (pol[i] == raw[i])); // R3
        end
      end
    end
  endgenerate

endmodule

// File: rtl/nn_cone.sv
module nn_cone
  import nn_cone_pkg::*;
#(
  parameter int unsigned LEVELS    = 6,
  parameter int unsigned TAP_FIRST = 3,
  parameter bit          EXT_INV   = 1'b0,
  localparam int unsigned LEAVES   = 1 << LEVELS,
  localparam int unsigned NODES    = LEAVES - 1,
  localparam int unsigned CFG_W    = NODES + LEAVES,
  localparam int unsigned TAP_BASE = LEAVES - (LEAVES >> (TAP_FIRST - 1)),
  localparam int unsigned OUT_W    = NODES - TAP_BASE
) (
  input  logic [LEAVES-1:0] leaf_in,
  input  logic [CFG_W-1:0]  cfg,
  output logic [OUT_W-1:0]  tap_out
);

  logic [LEAVES-1:0] fn_unused_guard;
  logic [LEAVES-1:0] leaf_pol;

  assign fn_unused_guard = cfg[CFG_W-1:NODES];

  nn_leaf_pol #(
    .WIDTH  (LEAVES),
    .EXT_INV(EXT_INV)
  ) u_pol (
    .raw (leaf_in),
    .flip(fn_unused_guard),
    .pol (leaf_pol)
  );

  generate
    for (genvar lv = 1; lv <= LEVELS; lv++) begin : g_lvl
      localparam int unsigned CNT  = lvl_count(LEAVES, lv);
      localparam int unsigned BASE = lvl_base(LEAVES, lv);
      logic [CNT-1:0] y;
      for (genvar j = 0; j < CNT; j++) begin : g_node
        logic a_in, b_in;
        if (lv == 1) begin : g_leafsrc
          assign a_in = leaf_pol[2*j];
          assign b_in = leaf_pol[2*j+1];
        end else begin : g_nodesrc
          assign a_in = g_lvl[lv-1].y[2*j];
          assign b_in = g_lvl[lv-1].y[2*j+1];
        end
        nn_node u_node (
          .in_a   (a_in),
          .in_b   (b_in),
          .sel_nor(cfg[BASE+j]),
          .y      (y[j])
        );
        if (lv >= TAP_FIRST) begin : g_tap
          assign tap_out[BASE-TAP_BASE+j] = y[j];
        end
      end
    end
  endgenerate

endmodule

// File: tb/nn_cone_tb.sv
module nn_cone_tb;

  localparam int LV     = 6;
  localparam int TF     = 3;
  localparam int NLEAF  = 1 << LV;
  localparam int NGATE  = NLEAF - 1;
  localparam int CW     = NGATE + NLEAF;
  localparam int OW     = 15;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic [NLEAF-1:0] leaves;
  logic [CW-1:0]    cfgv;
  logic [OW-1:0]    tap_int, tap_ext;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  nn_cone #(.LEVELS(LV), .TAP_FIRST(TF), .EXT_INV(1'b0)) u_dut (
    .leaf_in(leaves), .cfg(cfgv), .tap_out(tap_int));

  nn_cone #(.LEVELS(LV), .TAP_FIRST(TF), .EXT_INV(1'b1)) u_dut_ext (
    .leaf_in(leaves), .cfg(cfgv), .tap_out(tap_ext));

  // Behavioural model: walk the tree with a queue of values per level.
  function automatic logic [OW-1:0] model(input logic [NLEAF-1:0] lf,
                                          input logic [CW-1:0] c, input bit ext);
    bit cur[$];
    bit nxt[$];
    int fbit = 0;
    int oidx = 0;
    logic [OW-1:0] r = '0;
    for (int i = 0; i < NLEAF; i++)
      cur.push_back(ext ? lf[i] : (lf[i] ^ c[NGATE + i]));
    for (int l = 1; l <= LV; l++) begin
      nxt.delete();
      for (int k = 0; k < cur.size(); k += 2) begin
        bit x = cur[k];
        bit z = cur[k+1];
        bit v = c[fbit] ? !(x || z) : !(x && z);
        fbit++;
        nxt.push_back(v);
        if (l >= TF) begin
          r[oidx] = v;
          oidx++;
        end
      end
      cur = nxt;
    end
    return r;
  endfunction

  task automatic check(input string req, input logic [OW-1:0] got, input logic [OW-1:0] exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic apply(input logic [NLEAF-1:0] lf, input logic [CW-1:0] c);
    @(posedge clk);
    #1;
    leaves = lf;
    cfgv   = c;
    @(negedge clk);
  endtask

  function automatic logic [CW-1:0] rnd_cfg();
    logic [127:0] t = {$urandom, $urandom, $urandom, $urandom};
    return t[CW-1:0];
  endfunction

  logic [CW-1:0] all_nor;
  logic [CW-1:0] inv_on;

  initial begin
    leaves = '0;
    cfgv   = '0;
    all_nor = '0;
    all_nor[NGATE-1:0] = '1;
    inv_on = '0;
    inv_on[CW-1:NGATE] = '1;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;

    // R7: idle pattern, all NAND, leaves 0
    apply('0, '0);
    check("R7 nand leaves0", tap_int, 15'h30FF);
    check("R7 nand leaves0 ext", tap_ext, 15'h30FF);

    // R7 / R1: all NAND, leaves 1
    apply('1, '0);
    check("R7 nand leaves1", tap_int, 15'h4F00);

    // R1: all NOR
    apply('0, all_nor);
    check("R1 nor leaves0", tap_int, 15'h30FF);
    apply('1, all_nor);
    check("R1 nor leaves1", tap_int, 15'h4F00);

    // R3: inversion of every leaf turns zeros into ones
    apply('0, inv_on);
    check("R3 invert all", tap_int, 15'h4F00);
    // R4: external-polarity build ignores the same bits
    check("R4 ext ignores pol", tap_ext, 15'h30FF);
    apply('1, inv_on | all_nor);
    check("R4 ext ignores pol nor", tap_ext, 15'h4F00);
    check("R3 invert all nor", tap_int, 15'h30FF);

    // R8: immediate response, consecutive changes without settling clocks
    leaves = '1; cfgv = '0;
    #0.5;
    check("R8 comb response a", tap_int, 15'h4F00);
    leaves = '0;
    #0.5;
    check("R8 comb response b", tap_int, 15'h30FF);

    // R2 R5 R6: random configurations against the model
    for (int n = 0; n < 3000; n++) begin
      logic [NLEAF-1:0] lf = {$urandom, $urandom};
      logic [CW-1:0]    c  = rnd_cfg();
      apply(lf, c);
      check("R2 R5 R6 random int", tap_int, model(lf, c, 1'b0));
      check("R4 R6 random ext", tap_ext, model(lf, c, 1'b1));
    end

    // R4: flipping only polarity bits never moves the external-polarity taps
    for (int n = 0; n < 200; n++) begin
      logic [NLEAF-1:0] lf = {$urandom, $urandom};
      logic [CW-1:0]    c  = rnd_cfg();
      logic [OW-1:0]    first;
      apply(lf, c);
      first = tap_ext;
      apply(lf, c ^ {{NLEAF{1'b1}}, {NGATE{1'b0}}});
      check("R4 pol flip no effect", tap_ext, first);
    end

    done = 1'b1;
  end

  initial begin
    fork
      begin
        wait (done);
      end
      begin
        repeat (100000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule